// File: doc/BRIEF.md
# Floating-Point Class Mask Generator

This block sorts one IEEE-754 binary operand into one of ten classes and reports the class as a one-hot mask. The classes are the sign of infinities, normals, subnormals and zeros, plus a split of NaNs into signalling and quiet. A two-bit selector picks half, single or double precision. A narrower operand sits in the low bits of a 64-bit input, and the bits above it play no part. The 10-bit class word is zero-extended to a parameterised result width.

The classifier core has no clock. A single register stage with a valid flag wraps it, so it can be fed one operand per cycle. A vector or scalar floating-point unit would use it to implement its classify operation. The core does no rounding and raises no exception flags.

Top module: `fpcls_unit`

## Requirements
- R1: An infinity (exponent all ones, mantissa zero) yields mask bit 0 when the sign bit is 1 and bit 7 when the sign bit is 0.
- R2: A zero (exponent and mantissa all zero) yields bit 3 for sign 1 and bit 4 for sign 0.
- R3: A subnormal (exponent all zero, mantissa nonzero) yields bit 2 for sign 1 and bit 5 for sign 0.
- R4: A normal number (exponent neither all zero nor all ones) yields bit 1 for sign 1 and bit 6 for sign 0.
- R5: A NaN (exponent all ones, mantissa nonzero) yields bit 9 when the top mantissa bit is 1 (quiet) and bit 8 when it is 0 (signalling), whatever the sign.
- R6: `in_fmt` 0 selects half precision (sign bit 15, 5 exponent bits, 10 mantissa bits). Value 1 selects single precision (sign bit 31, 8 and 23 bits). Value 2 selects double precision (sign bit 63, 11 and 52 bits). Value 3 is treated as double.
- R7: Operand bits above the selected format's sign bit have no effect on the result.
- R8: Every accepted operand gives exactly one set bit among mask bits 9..0, and mask bits at position 10 and above are always zero.
- R9: `out_valid` is high in the cycle after a cycle with `in_valid` high and low otherwise. Synchronous active-low reset clears `out_valid` and `out_mask`.
- R10: While `in_valid` is low, `out_mask` keeps the class of the last accepted operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| in_fmt | input | 2 | Precision select (0 half, 1 single, 2 or 3 double) |
| in_operand | input | 64 | Operand, right-aligned for narrow formats |
| out_valid | output | 1 | Class mask updated from the previous cycle's operand |
| out_mask | output | RES_W (64) | Zero-extended one-hot class mask |

## Verification
Two things can happen in the same cycle. The register stage presents the class of one operand while it accepts the next one. That next operand may be in a different format, or it may sit at the other side of an encoding boundary, such as an infinity followed by a one-ulp NaN. The bench streams operands back to back, one per cycle. The stream covers every half-precision encoding and a mix of boundary and pseudo-random single and double patterns. After each edge the bench compares the presented mask against a class computed arithmetically for the operand driven one cycle earlier. Idle gaps with junk on the operand lines are mixed in to judge the hold behaviour against the same stream.

// File: rtl/fpcls_pkg.sv
// Package: shared constants and types for the floating-point class mask unit.
// Assumes three supported binary formats; index 2 is the widest (double).
package fpcls_pkg;

    localparam int NUM_FMT = 3;
    localparam int NUM_CLS = 10;

    // Mask bit positions; these are decoded by the consumer of the mask.
    localparam int CLS_NEG_INF  = 0;
    localparam int CLS_NEG_NORM = 1;
    localparam int CLS_NEG_SUB  = 2;
    localparam int CLS_NEG_ZERO = 3;
    localparam int CLS_POS_ZERO = 4;
    localparam int CLS_POS_SUB  = 5;
    localparam int CLS_POS_NORM = 6;
    localparam int CLS_POS_INF  = 7;
    localparam int CLS_SNAN     = 8;
    localparam int CLS_QNAN     = 9;

    typedef enum logic [1:0] {
        FMT_HALF   = 2'd0,
        FMT_SINGLE = 2'd1,
        FMT_DOUBLE = 2'd2,
        FMT_RSVD   = 2'd3
    } fmt_e;

    // Summary of the fields of one operand, independent of width.
    typedef struct packed {
        logic sign;
        logic exp_zero;
        logic exp_ones;
        logic man_zero;
        logic man_msb;
    } fp_fields_t;

    function automatic int fmt_exp_w(input int idx);
        case (idx)
            0:       return 5;
            1:       return 8;
            default: return 11;
        endcase
    endfunction

    function automatic int fmt_man_w(input int idx);
        case (idx)
            0:       return 10;
            1:       return 23;
            default: return 52;
        endcase
    endfunction

endpackage

// File: rtl/fpcls_field_decode.sv
// Module: reduces an operand to its sign/exponent/mantissa summary for the
// selected format. Assumes OP_W covers the widest format; bits above the
// selected format's sign bit are ignored.
module fpcls_field_decode
    import fpcls_pkg::*;
#(
    parameter int OP_W = 64
) (
    input  logic [OP_W-1:0] operand,
    input  fmt_e            fmt,
    output fp_fields_t      fields
);

    fp_fields_t per_fmt [NUM_FMT];

    // One field summary per supported format, evaluated in parallel.
    for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
        localparam int EW = fmt_exp_w(g);
        localparam int MW = fmt_man_w(g);
        logic [EW-1:0] exp_f;
        logic [MW-1:0] man_f;
        assign exp_f = operand[MW +: EW];
        assign man_f = operand[MW-1:0];
        assign per_fmt[g].sign     = operand[EW+MW];
        assign per_fmt[g].exp_zero = ~|exp_f;
        assign per_fmt[g].exp_ones = &exp_f;
        assign per_fmt[g].man_zero = ~|man_f;
        assign per_fmt[g].man_msb  = man_f[MW-1];
    end

    // Select the summary of the requested format; reserved code maps to double.
    always_comb begin
        case (fmt)
            FMT_HALF:   fields = per_fmt[0];
            FMT_SINGLE: fields = per_fmt[1];
            default:    fields = per_fmt[2];
        endcase
    end

endmodule

// File: rtl/fpcls_class_encode.sv
// Module: turns a field summary into the 10-bit one-hot class word.
// Assumes the summary is consistent (exp_zero and exp_ones never both set).
module fpcls_class_encode
    import fpcls_pkg::*;
(
    input  fp_fields_t         fields,
    output logic [NUM_CLS-1:0] cls
);

    // Priority: infinity, zero, subnormal, NaN, then normal.
    always_comb begin
        cls = '0;
        if (fields.exp_ones && fields.man_zero) begin
            cls[fields.sign ? CLS_NEG_INF : CLS_POS_INF] = 1'b1;
        end else if (fields.exp_zero && fields.man_zero) begin
            cls[fields.sign ? CLS_NEG_ZERO : CLS_POS_ZERO] = 1'b1;
        end else if (fields.exp_zero) begin
            cls[fields.sign ? CLS_NEG_SUB : CLS_POS_SUB] = 1'b1;
        end else if (fields.exp_ones) begin
            cls[fields.man_msb ? CLS_QNAN : CLS_SNAN] = 1'b1;
        end else begin
            cls[fields.sign ? CLS_NEG_NORM : CLS_POS_NORM] = 1'b1;
        end
    end

endmodule

// File: rtl/fpcls_unit.sv
// Module: registered floating-point class mask unit. Accepts one operand per
// cycle under in_valid and presents its zero-extended class mask one cycle
// later. Assumes RES_W > 10 and a 64-bit operand bus.
module fpcls_unit
    import fpcls_pkg::*;
#(
    parameter int RES_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       in_fmt,
    input  logic [63:0]      in_operand,
    output logic             out_valid,
    output logic [RES_W-1:0] out_mask
);

    localparam int OP_W  = 64;
    localparam int PAD_W = RES_W - NUM_CLS;

    fp_fields_t         fields;
    logic [NUM_CLS-1:0] cls;

    fpcls_field_decode #(.OP_W(OP_W)) u_decode (
        .operand (in_operand),
        .fmt     (fmt_e'(in_fmt)),
        .fields  (fields)
    );

    fpcls_class_encode u_encode (
        .fields (fields),
        .cls    (cls)
    );

    // Valid flag: follows in_valid with one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Result register: loads the zero-extended class on accept, else holds.
    always_ff @(posedge clk) begin
        if (!rst_n)        out_mask <= '0;
        else if (in_valid) out_mask <= {{PAD_W{1'b0}}, cls};
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                   // R9
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);                                 // R9
    AST_MASK_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones(out_mask[NUM_CLS-1:0]) == 1);     // R8
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_mask[RES_W-1:NUM_CLS] == '0);                          // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_mask));                          // R10

endmodule

// File: tb/fpcls_unit_tb_top.sv
// Bench: streams operands one per cycle and compares each presented mask with
// a class computed arithmetically from the requirements.
module fpcls_unit_tb_top;

    localparam int RES_W = 64;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [1:0]       in_fmt = 2'd0;
    logic [63:0]      in_operand = '0;
    logic             out_valid;
    logic [RES_W-1:0] out_mask;

    int tests = 0;
    int fails = 0;

    logic             pend_v = 1'b0;
    logic [63:0]      pend_exp = '0;
    logic [63:0]      last_mask = '0;
    logic [63:0]      lfsr = 64'h9E37_79B9_7F4A_7C15;

    always #2.5 clk = ~clk;

    fpcls_unit #(.RES_W(RES_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_fmt     (in_fmt),
        .in_operand (in_operand),
        .out_valid  (out_valid),
        .out_mask   (out_mask)
    );

    function automatic logic [63:0] ref_mask(input logic [1:0] f, input logic [63:0] op);
        int ew, mw;
        logic [63:0] e, m, emax;
        logic s;
        ew = (f == 2'd0) ? 5 : (f == 2'd1) ? 8 : 11;
        mw = (f == 2'd0) ? 10 : (f == 2'd1) ? 23 : 52;
        emax = (64'd1 << ew) - 64'd1;
        e = (op >> mw) & emax;
        m = op & ((64'd1 << mw) - 64'd1);
        s = op[ew + mw];
        if (e == emax && m == 0)  return s ? 64'd1   : 64'd128;
        if (e == 0 && m == 0)     return s ? 64'd8   : 64'd16;
        if (e == 0)               return s ? 64'd4   : 64'd32;
        if (e == emax)            return ((m >> (mw - 1)) & 64'd1) != 0 ? 64'd512 : 64'd256;
        return s ? 64'd2 : 64'd64;
    endfunction

    function automatic string req_of(input logic [63:0] m);
        case (m)
            64'd1, 64'd128:  return "R1";
            64'd8, 64'd16:   return "R2";
            64'd4, 64'd32:   return "R3";
            64'd2, 64'd64:   return "R4";
            default:         return "R5";
        endcase
    endfunction

    function automatic logic [63:0] next_lfsr(input logic [63:0] v);
        return {v[62:0], v[63] ^ v[62] ^ v[60] ^ v[59]};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: judge the result of the previous drive, then drive anew.
    task automatic step(input logic v, input logic [1:0] f, input logic [63:0] op);
        @(negedge clk);
        check("R9", {63'd0, out_valid}, {63'd0, pend_v});
        if (pend_v) begin
            check(req_of(pend_exp), out_mask, pend_exp);
            last_mask = pend_exp;
        end else begin
            check("R10", out_mask, last_mask);
        end
        in_valid   = v;
        in_fmt     = f;
        in_operand = op;
        pend_v     = v;
        pend_exp   = ref_mask(f, op);
    endtask

    // Boundary patterns for one format: extreme exponents and mantissas.
    task automatic sweep_edges(input logic [1:0] f, input int ew, input int mw);
        logic [63:0] mans [6];
        logic [63:0] emax;
        emax = (64'd1 << ew) - 64'd1;
        mans[0] = 64'd0;
        mans[1] = 64'd1;
        mans[2] = 64'd1 << (mw - 1);
        mans[3] = (64'd1 << (mw - 1)) | 64'd1;
        mans[4] = (64'd1 << mw) - 64'd1;
        mans[5] = (64'd1 << (mw - 1)) - 64'd1;
        for (int s = 0; s < 2; s++) begin
            for (int ei = 0; ei < 5; ei++) begin
                logic [63:0] e;
                e = (ei == 0) ? 64'd0 : (ei == 1) ? 64'd1 : (ei == 2) ? emax - 64'd1 :
                    (ei == 3) ? emax : (emax >> 1);
                for (int mi = 0; mi < 6; mi++) begin
                    logic [63:0] op;
                    op = (64'(s) << (ew + mw)) | (e << mw) | mans[mi];
                    lfsr = next_lfsr(lfsr);
                    // R7: junk above the sign bit of narrow formats
                    if (ew + mw + 1 < 64) op = op | ((lfsr << (ew + mw + 1)));
                    step(1'b1, f, op);
                end
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9", {63'd0, out_valid}, 64'd0);
        check("R9", out_mask, 64'd0);
        rst_n = 1'b1;

        // R6/R7: every half-precision encoding, junk in the upper 48 bits
        for (int i = 0; i < 65536; i++) begin
            lfsr = next_lfsr(lfsr);
            step(1'b1, 2'd0, {lfsr[47:0], 16'(i)});
        end

        sweep_edges(2'd0, 5, 10);
        sweep_edges(2'd1, 8, 23);
        sweep_edges(2'd2, 11, 52);
        sweep_edges(2'd3, 11, 52);   // R6: reserved code behaves as double

        // R6: formats alternate every cycle; R10: idle gaps with junk operands
        for (int i = 0; i < 12000; i++) begin
            logic [63:0] op;
            lfsr = next_lfsr(lfsr);
            op = lfsr;
            if (lfsr[5:4] == 2'b00) op[62:52] = 11'h7FF;
            if (lfsr[5:4] == 2'b01) op[30:23] = 8'h00;
            if (lfsr[7:6] == 2'b11) step(1'b0, lfsr[9:8], ~op);
            else                    step(1'b1, 2'(i % 4), op);
        end

        // R10: a long idle run must keep the last class
        for (int i = 0; i < 20; i++) begin
            lfsr = next_lfsr(lfsr);
            step(1'b0, lfsr[1:0], lfsr);
        end
        step(1'b0, 2'd0, '0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule